// File: doc/BRIEF.md
# Pixel Clock Divider with Bypass

This block derives the panel pixel timing from a reference clock. A divisor is held as two separate fields, a low part and a high part. Joined with the high part on top, the two fields give a value that is two below the division ratio. A separate bypass control selects divide-by-one, where the divisor fields play no part. The block produces a one-cycle pixel enable, for the downstream pixel pipeline, on the reference clock domain. It also drives the panel clock pin, which can be inverted to pick the launching edge.

Settings are sampled only at the end of an output period. A change to the divisor or to bypass therefore never cuts a clock phase short. For odd ratios the high phase is the shorter one. Software picks the divisor that best fits a target rate; this block only applies it.

Top module: `pix_clk_div`

## Requirements
- R1: While rst_ni is low, pix_en_o is 0 and pix_clk_o equals clk_inv_i, so the pin idles low when it is not inverted.
- R2: With bypass applied, pix_en_o is 1 in every reference cycle. pix_clk_o follows clk_i (XOR clk_inv_i), and the divisor fields have no effect.
- R3: With bypass clear, the ratio N is {div_hi_i, div_lo_i} + 2. pix_en_o is high for exactly one reference cycle in every N.
- R4: div_hi_i supplies the upper HI_W bits of the divisor value and div_lo_i the lower LO_W bits. In the small configuration, hi=1 with lo=0 gives ratio 6.
- R5: The ratio is capped at 2^(LO_W+HI_W) - 1. Divisor values whose sum with 2 would exceed this give that maximum. The smallest divided ratio is 2.
- R6: In each divided period the non-inverted pin is high for floor(N/2) reference cycles, starting with the enable cycle, and low for the rest of the period.
- R7: clk_inv_i inverts pix_clk_o in both divided and bypass modes.
- R8: Divisor and bypass inputs are sampled only at the last cycle of an output period. The period in progress completes with the old ratio, and the new setting governs from the next enable onwards.
- R9: The enable cycle is the first high cycle of the non-inverted pin, so the rising edge coincides with the start of pix_en_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | Divide-by-one select |
| div_lo_i | input | LO_W | Low part of the divisor value |
| div_hi_i | input | HI_W | High part of the divisor value |
| clk_inv_i | input | 1 | Inverts the panel clock pin |
| pix_en_o | output | 1 | One-cycle pixel enable per output period |
| pix_clk_o | output | 1 | Panel clock pin |

## Verification
Settings go in at a falling edge. They take hold at the rising edge that ends the current output period, and the first enable under the new setting is visible at the following falling edge. The bench therefore measures only whole periods that begin at an observed enable, or counts enables across a change. Divided outputs come from registers and are sampled at falling edges. In bypass the pin is sampled just after both clock edges, because it follows the reference clock combinationally. Every divisor value of a 2+2-bit configuration is swept, and the expected period and high phase are computed as min(v+2, 15) and floor(N/2).

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int unsigned MIN_RATIO = 2;

  typedef enum logic {
    SRC_DIVIDED   = 1'b0,
    SRC_REFERENCE = 1'b1
  } clk_src_e;
endpackage

// File: rtl/pcd_ratio_merge.sv
module pcd_ratio_merge #(
  parameter int unsigned LO_W = 5,
  parameter int unsigned HI_W = 5,
  localparam int unsigned DIV_W = LO_W + HI_W
) (
  input  logic [LO_W-1:0]  lo_i,
  input  logic [HI_W-1:0]  hi_i,
  output logic [DIV_W-1:0] ratio_o
);
  localparam logic [DIV_W:0] RATIO_MAX = {1'b0, {DIV_W{1'b1}}};

  logic [DIV_W:0] sum;

  always_comb begin
    sum = {1'b0, hi_i, lo_i} + (DIV_W+1)'(pcd_pkg::MIN_RATIO);
    // saturate: largest reachable ratio is all-ones
    ratio_o = (sum > RATIO_MAX) ? RATIO_MAX[DIV_W-1:0] : sum[DIV_W-1:0];
  end
endmodule

// File: rtl/pcd_period_counter.sv
module pcd_period_counter #(
  parameter int unsigned RATIO_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bypass_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               byp_o,
  output logic               start_o,
  output logic               clk_o
);
  logic               byp_q;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               clk_q;
  logic [RATIO_W-1:0] cnt_inc;
  logic [RATIO_W-1:0] half_q;
  logic               last;

  assign cnt_inc = cnt_q + RATIO_W'(1);
  assign half_q  = ratio_q >> 1;
  assign last    = byp_q || (cnt_inc == ratio_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q   <= 1'b0;
      ratio_q <= RATIO_W'(pcd_pkg::MIN_RATIO);
      cnt_q   <= RATIO_W'(1);  // first edge out of reset is a boundary
      clk_q   <= 1'b0;
    end else if (last) begin
      byp_q   <= bypass_i;
      ratio_q <= ratio_i;
      cnt_q   <= '0;
      clk_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_inc;
      clk_q   <= (cnt_inc < half_q);
    end
  end

  assign byp_o   = byp_q;
  assign start_o = byp_q || (cnt_q == '0);
  assign clk_o   = clk_q;

  assert_cnt_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  assert_ratio_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= RATIO_W'(pcd_pkg::MIN_RATIO));
  assert_hold_midperiod_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> ($stable(ratio_q) && $stable(byp_q)));
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !byp_q) |=> !start_o);
  assert_rise_at_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q && $rose(clk_q)) |-> (cnt_q == '0));
  assert_fall_at_half_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byp_q && $fell(clk_q)) |-> (cnt_q == half_q));
endmodule

// File: rtl/pcd_pin_drive.sv
module pcd_pin_drive (
  input  logic              clk_i,
  input  pcd_pkg::clk_src_e src_i,
  input  logic              div_clk_i,
  input  logic              invert_i,
  output logic              pin_o
);
  logic raw;

  always_comb begin
    unique case (src_i)
      pcd_pkg::SRC_REFERENCE: raw = clk_i;
      default:                raw = div_clk_i;
    endcase
    pin_o = raw ^ invert_i;
  end
endmodule

// File: rtl/pix_clk_div.sv
module pix_clk_div #(
  parameter int unsigned LO_W = 5,
  parameter int unsigned HI_W = 5,
  localparam int unsigned RATIO_W = LO_W + HI_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bypass_i,
  input  logic [LO_W-1:0] div_lo_i,
  input  logic [HI_W-1:0] div_hi_i,
  input  logic            clk_inv_i,
  output logic            pix_en_o,
  output logic            pix_clk_o
);
  logic [RATIO_W-1:0] ratio;
  logic               byp;
  logic               div_clk;
  pcd_pkg::clk_src_e  src;

  pcd_ratio_merge #(.LO_W(LO_W), .HI_W(HI_W)) u_merge (
    .lo_i    (div_lo_i),
    .hi_i    (div_hi_i),
    .ratio_o (ratio)
  );

  pcd_period_counter #(.RATIO_W(RATIO_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .ratio_i  (ratio),
    .byp_o    (byp),
    .start_o  (pix_en_o),
    .clk_o    (div_clk)
  );

  assign src = byp ? pcd_pkg::SRC_REFERENCE : pcd_pkg::SRC_DIVIDED;

  pcd_pin_drive u_pin (
    .clk_i     (clk_i),
    .src_i     (src),
    .div_clk_i (div_clk),
    .invert_i  (clk_inv_i),
    .pin_o     (pix_clk_o)
  );

  assert_bypass_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(byp) |-> pix_en_o || !byp);
endmodule

// File: tb/pix_clk_div_bench.sv
module pix_clk_div_bench;
  localparam int unsigned LO_W = 2;
  localparam int unsigned HI_W = 2;
  localparam int RMAX = (1 << (LO_W + HI_W)) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0;
  logic [LO_W-1:0] lo = '0;
  logic [HI_W-1:0] hi = '0;
  logic inv = 1'b0;
  logic pix_en;
  logic pix_clk;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pix_clk_div #(.LO_W(LO_W), .HI_W(HI_W)) u_pix_clk_div (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bypass_i  (bypass),
    .div_lo_i  (lo),
    .div_hi_i  (hi),
    .clk_inv_i (inv),
    .pix_en_o  (pix_en),
    .pix_clk_o (pix_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ratio(input int v);
    return (v + 2 > RMAX) ? RMAX : v + 2;
  endfunction

  task automatic set_div(input int v);
    lo = v[LO_W-1:0];
    hi = v[LO_W+HI_W-1:LO_W];
  endtask

  // cycles until the next enable is seen at a falling edge
  task automatic cycles_to_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pix_en && n < 64);
  endtask

  // measure one full period starting at the next enable
  task automatic measure(input int n, input bit pinv, input string req);
    int dummy;
    int k;
    int mism;
    cycles_to_start(dummy);
    check(pix_clk == !pinv, "R9", int'(pix_clk), int'(!pinv));
    k = 0;
    mism = 0;
    do begin
      if (pix_clk != ((k < n / 2) ^ pinv)) mism++;
      @(negedge clk);
      k++;
    end while (!pix_en && k < 64);
    check(k == n, req, k, n);
    check(mism == 0, "R6", mism, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(pix_en == 1'b0, "R1", int'(pix_en), 0);
    check(pix_clk == 1'b0, "R1", int'(pix_clk), 0);
    inv = 1'b1;
    @(negedge clk);
    check(pix_clk == 1'b1, "R1", int'(pix_clk), 1);
    inv = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R3/R4/R5 sweep of every divisor value
    for (int v = 0; v < (1 << (LO_W + HI_W)); v++) begin
      set_div(v);
      if (v + 2 > RMAX)            measure(exp_ratio(v), 1'b0, "R5");
      else if (v[LO_W-1:0] == '0 && v != 0) measure(exp_ratio(v), 1'b0, "R4");
      else                         measure(exp_ratio(v), 1'b0, "R3");
    end

    // R7 inverted pin, odd ratio
    inv = 1'b1;
    set_div(3);
    measure(5, 1'b1, "R7");
    inv = 1'b0;

    // R8 change mid-period applies at boundary
    set_div(1);
    measure(3, 1'b0, "R3");
    set_div(6);
    cycles_to_start(c);
    check(c == 3, "R8", c, 3);
    cycles_to_start(c);
    check(c == 8, "R8", c, 8);

    // R2 bypass
    bypass = 1'b1;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      set_div(i * 2);
      check(pix_en == 1'b1, "R2", int'(pix_en), 1);
      check(pix_clk == 1'b0, "R2", int'(pix_clk), 0);
      @(posedge clk);
      #2;
      check(pix_clk == 1'b1, "R2", int'(pix_clk), 1);
      @(negedge clk);
    end
    inv = 1'b1;
    #2;
    check(pix_clk == 1'b1, "R7", int'(pix_clk), 1);
    @(negedge clk);
    inv = 1'b0;
    bypass = 1'b0;
    set_div(2);
    measure(4, 1'b0, "R2");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule